// File: doc/BRIEF.md
# Three-Phase Current Fault Trip Detector

This block watches three signed phase-current sample streams that arrive together under a sample strobe. It raises a latched trip output when any phase breaks a magnitude limit or a rate-of-change limit. Each phase is smoothed by a unity-gain first-order low-pass filter built from a right shift, so short switching spikes are damped. The filtered value is then taken as an absolute value and tested two ways. Its size is compared with a programmable peak limit. The difference between two successive filtered samples is compared with a programmable slope limit, which is already scaled by the sample period so that no divider is needed.

Detection is held off in two stages. After reset, or after a clear, a start-up blanking timer runs first. Once it has expired, each phase arms only at the next sign change of its own filtered current. A comparator hit on an armed phase is captured by its own flag after a fixed settling delay, and the flag then stays high. The three magnitude flags are ORed into a magnitude-trip output, and all six flags are ORed into the final trip. Flags, arming and blanking restart only on reset or on the clear input.

Top module: `phase_fault_trip`

## Requirements
- R1: On each cycle with `smp_valid` high, each phase's filter state f becomes f + ((x - f) >>> FILT_SHIFT), where x is the phase sample and >>> is an arithmetic right shift. Without the strobe the state holds. A single-sample spike therefore reaches the comparators only in attenuated form.
- R2: For BLANK_CYCLES clock cycles after reset falls, and again after each `clr`, no phase can arm, even if its filtered current changes sign in that window.
- R3: Once blanking has expired, a phase arms on the first strobed sample whose new filtered value has a different sign from the previous one (negative versus non-negative). Only samples after that arming sample are tested, so no flag can start before the crossing.
- R4: Both comparisons use absolute values. The filter clamps its state to the range ±(2^15 - 1), so a run of the most negative sample (-32768) gives a magnitude of 32767.
- R5: An armed phase records a magnitude hit when |new filtered value| > `mag_limit` (16-bit unsigned).
- R6: An armed phase records a slope hit when |new filtered value - previous filtered value| > `slope_limit` (16-bit unsigned).
- R7: A flag rises exactly SETTLE_CYCLES clock edges after the edge that sampled its first hit. Further hits in that window are ignored, and the flag then stays high until reset or `clr`.
- R8: `mag_trip` is the OR of the three magnitude flags. `trip` is the OR of all six flags, so a slope-only fault raises `trip` with `mag_trip` low.
- R9: `clr` (synchronous) clears all flags, pending captures, arming state and the blanking timer in one edge. The filter state is kept.
- R10: While `rst` is high (synchronous, active high), all flags, `mag_trip` and `trip` are 0 and the filter states are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of flags, arming and blanking |
| smp_valid | input | 1 | Strobe: the three samples are new this cycle |
| cur_a | input | 16 | Phase A current sample, two's complement |
| cur_b | input | 16 | Phase B current sample, two's complement |
| cur_c | input | 16 | Phase C current sample, two's complement |
| mag_limit | input | 16 | Peak magnitude limit, unsigned |
| slope_limit | input | 16 | Per-sample slope limit, unsigned |
| mag_flags | output | 3 | Latched magnitude flags, bit 0 = phase A |
| slope_flags | output | 3 | Latched slope flags, bit 0 = phase A |
| mag_trip | output | 1 | OR of the magnitude flags |
| trip | output | 1 | OR of all six flags |

## Verification
The bench drives a sign change during blanking and then holds the phase over the limit. A design that arms during blanking, or that arms without a crossing, would flag that phase. A single large spike is applied with the slope test opened up, to show that the filter keeps it below the peak limit. The same spike is then repeated with a tight slope limit, and the flag is sampled one edge before and exactly at the settling point. A delay that is off by one fails there, as does a flag that is not sticky. A slow negative ramp exposes a design that skips the absolute value. A long run of -32768 is used to show that a filter without the clamp, or an absolute value that wraps, behaves differently near full scale.

// File: rtl/pft_pkg.sv
package pft_pkg;

  parameter int unsigned PFT_W = 16;

  localparam logic signed [PFT_W+1:0] PFT_HI = (PFT_W+2)'((2 ** (PFT_W - 1)) - 1);
  localparam logic signed [PFT_W+1:0] PFT_LO = -PFT_HI;

  // first-order smoothing step with alpha = 2^-k, clamped to a symmetric range
  function automatic logic signed [PFT_W-1:0] lpf_next(
    input logic signed [PFT_W-1:0] f,
    input logic signed [PFT_W-1:0] x,
    input int unsigned k
  );
    logic signed [PFT_W+1:0] fe, xe, d, s;
    fe = $signed({{2{f[PFT_W-1]}}, f});
    xe = $signed({{2{x[PFT_W-1]}}, x});
    d  = xe - fe;
    s  = fe + (d >>> k);
    if (s > PFT_HI)      s = PFT_HI;
    else if (s < PFT_LO) s = PFT_LO;
    return s[PFT_W-1:0];
  endfunction

  function automatic logic [PFT_W-1:0] abs_val(input logic signed [PFT_W-1:0] v);
    logic signed [PFT_W-1:0] n;
    n = -v;
    return v[PFT_W-1] ? $unsigned(n) : $unsigned(v);
  endfunction

  function automatic logic [PFT_W-1:0] abs_diff(
    input logic signed [PFT_W-1:0] a,
    input logic signed [PFT_W-1:0] b
  );
    logic signed [PFT_W:0] d, n;
    d = $signed({a[PFT_W-1], a}) - $signed({b[PFT_W-1], b});
    n = -d;
    return d[PFT_W] ? n[PFT_W-1:0] : d[PFT_W-1:0];
  endfunction

endpackage

// File: rtl/pft_blank_timer.sv
module pft_blank_timer #(
  parameter int unsigned BLANK = 200_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int unsigned CW = $clog2(BLANK + 1);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == CW'(BLANK));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> done); // R2

endmodule

// File: rtl/pft_delay_latch.sv
module pft_delay_latch #(
  parameter int unsigned SETTLE = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic flag
);
  localparam int unsigned DW = $clog2(SETTLE + 1);

  logic          pend_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      flag   <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q == DW'(SETTLE - 1)) begin
        flag   <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (hit && !flag) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  AST_FLAG_AFTER_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(pend_q)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R7

endmodule

// File: rtl/pft_channel.sv
module pft_channel
  import pft_pkg::*;
#(
  parameter int unsigned K      = 2,
  parameter int unsigned SETTLE = 2000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    valid,
  input  logic                    blank_done,
  input  logic signed [PFT_W-1:0] sample,
  input  logic        [PFT_W-1:0] mag_limit,
  input  logic        [PFT_W-1:0] slope_limit,
  output logic                    mag_flag,
  output logic                    slope_flag
);
  localparam logic signed [PFT_W-1:0] FMIN = {1'b1, {(PFT_W-1){1'b0}}};
  localparam int unsigned NCMP = 2;

  logic signed [PFT_W-1:0] filt_q, filt_nx;
  logic        [PFT_W-1:0] mag_abs, slope_abs;
  logic                    zero_cross, mag_over, slope_over, armed_q;
  logic        [NCMP-1:0]  hit, flag;

  assign filt_nx    = lpf_next(filt_q, sample, K);
  assign mag_abs    = abs_val(filt_nx);
  assign slope_abs  = abs_diff(filt_nx, filt_q);
  assign zero_cross = filt_nx[PFT_W-1] != filt_q[PFT_W-1];
  assign mag_over   = mag_abs > mag_limit;
  assign slope_over = slope_abs > slope_limit;

  assign hit[0] = valid && armed_q && mag_over;
  assign hit[1] = valid && armed_q && slope_over;

  always_ff @(posedge clk) begin
    if (rst)        filt_q <= '0;
    else if (valid) filt_q <= filt_nx;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                            armed_q <= 1'b0;
    else if (valid && blank_done && zero_cross) armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_lat
    pft_delay_latch #(.SETTLE(SETTLE)) u_lat (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .hit  (hit[g]),
      .flag (flag[g])
    );
  end

  assign mag_flag   = flag[0];
  assign slope_flag = flag[1];

  AST_FILT_NOT_MIN: assert property (@(posedge clk) disable iff (rst)
    filt_q != FMIN); // R4

  AST_ARM_AFTER_BLANK: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(blank_done)); // R2

  AST_FLAG_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    ($rose(mag_flag) || $rose(slope_flag)) |-> armed_q); // R3

endmodule

// File: rtl/phase_fault_trip.sv
module phase_fault_trip
  import pft_pkg::*;
#(
  parameter int unsigned FILT_SHIFT    = 2,
  parameter int unsigned BLANK_CYCLES  = 200_000_000,
  parameter int unsigned SETTLE_CYCLES = 2000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    smp_valid,
  input  logic signed [PFT_W-1:0] cur_a,
  input  logic signed [PFT_W-1:0] cur_b,
  input  logic signed [PFT_W-1:0] cur_c,
  input  logic        [PFT_W-1:0] mag_limit,
  input  logic        [PFT_W-1:0] slope_limit,
  output logic        [2:0]       mag_flags,
  output logic        [2:0]       slope_flags,
  output logic                    mag_trip,
  output logic                    trip
);
  localparam int unsigned NPH = 3;

  logic signed [PFT_W-1:0] samp [NPH];
  logic                    blank_done;

  assign samp[0] = cur_a;
  assign samp[1] = cur_b;
  assign samp[2] = cur_c;

  pft_blank_timer #(.BLANK(BLANK_CYCLES)) u_blank (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .done (blank_done)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    pft_channel #(.K(FILT_SHIFT), .SETTLE(SETTLE_CYCLES)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .clr         (clr),
      .valid       (smp_valid),
      .blank_done  (blank_done),
      .sample      (samp[p]),
      .mag_limit   (mag_limit),
      .slope_limit (slope_limit),
      .mag_flag    (mag_flags[p]),
      .slope_flag  (slope_flags[p])
    );
  end

  assign mag_trip = |mag_flags;
  assign trip     = mag_trip || (|slope_flags);

  AST_MAG_IMPLIES_TRIP: assert property (@(posedge clk) disable iff (rst)
    mag_trip |-> trip); // R8

  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (trip && !clr) |=> trip); // R7

endmodule

// File: tb/tb_phase_fault_trip.sv
`timescale 1ns/1ps
module tb_phase_fault_trip;
  localparam int K = 2;
  localparam int BLANK = 40;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst, clr, vld;
  logic signed [15:0] ca, cb, cc;
  logic [15:0] mlim, slim;
  logic [2:0] mag_flags, slope_flags;
  logic mag_trip, trip;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  phase_fault_trip #(.FILT_SHIFT(K), .BLANK_CYCLES(BLANK), .SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst(rst), .clr(clr), .smp_valid(vld),
    .cur_a(ca), .cur_b(cb), .cur_c(cc),
    .mag_limit(mlim), .slope_limit(slim),
    .mag_flags(mag_flags), .slope_flags(slope_flags),
    .mag_trip(mag_trip), .trip(trip)
  );

  // behavioural reference model
  int m_f [3];
  bit m_arm [3];
  bit m_pend [6];
  bit m_flag [6];
  int m_left [6];
  int m_bc;
  int nf_v [3];
  bit ht_v [6];
  bit dn_v;

  function automatic int smooth(int f, int x);
    int s;
    s = f + ((x - f) >>> K);
    if (s > 32767) s = 32767;
    if (s < -32767) s = -32767;
    return s;
  endfunction

  function automatic int mag(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int pick(int ch);
    if (ch == 0) return int'(ca);
    if (ch == 1) return int'(cb);
    return int'(cc);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin m_f[i] = 0; m_arm[i] = 0; end
      for (int j = 0; j < 6; j++) begin m_pend[j] = 0; m_flag[j] = 0; m_left[j] = 0; end
      m_bc = 0;
    end else begin
      dn_v = (m_bc >= BLANK);
      for (int i = 0; i < 3; i++) begin
        nf_v[i] = smooth(m_f[i], pick(i));
        ht_v[i]   = vld && m_arm[i] && (mag(nf_v[i]) > int'(mlim));
        ht_v[3+i] = vld && m_arm[i] && (mag(nf_v[i] - m_f[i]) > int'(slim));
      end
      for (int j = 0; j < 6; j++) begin
        if (clr) begin
          m_pend[j] = 0; m_flag[j] = 0;
        end else if (m_pend[j]) begin
          m_left[j]--;
          if (m_left[j] == 0) begin m_flag[j] = 1; m_pend[j] = 0; end
        end else if (ht_v[j] && !m_flag[j]) begin
          m_pend[j] = 1; m_left[j] = SETTLE;
        end
      end
      if (clr) begin
        for (int i = 0; i < 3; i++) m_arm[i] = 0;
        m_bc = 0;
      end else begin
        for (int i = 0; i < 3; i++)
          if (vld && dn_v && ((nf_v[i] < 0) != (m_f[i] < 0))) m_arm[i] = 1;
        if (m_bc < BLANK) m_bc++;
      end
      if (vld) for (int i = 0; i < 3; i++) m_f[i] = nf_v[i];
    end
  end

  // per-cycle comparison against the model (R5 R6 R7 R8)
  always @(negedge clk) begin
    logic [7:0] exp_v, act_v;
    exp_v = {m_flag[2], m_flag[1], m_flag[0], m_flag[5], m_flag[4], m_flag[3],
             m_flag[0] | m_flag[1] | m_flag[2],
             m_flag[0] | m_flag[1] | m_flag[2] | m_flag[3] | m_flag[4] | m_flag[5]};
    act_v = {mag_flags, slope_flags, mag_trip, trip};
    if (!finished) begin
      tests++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL model R5 R6 R7 R8 at %0t: actual %b expected %b", $time, act_v, exp_v);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send(input int a, input int b, input int c);
    @(negedge clk);
    ca = 16'(a); cb = 16'(b); cc = 16'(c); vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst = 1; clr = 0; vld = 0; ca = 0; cb = 0; cc = 0;
    mlim = 16'd10000; slim = 16'd3000;
    idle(3);
    check(trip == 0 && mag_trip == 0 && mag_flags == 0 && slope_flags == 0, "R10 reset", int'(trip), 0);
    rst = 0;

    // crossing inside the blanking window must not arm (R2)
    repeat (4) send(20000, 0, 0);
    repeat (4) send(-20000, 0, 0);
    idle(30);
    check(trip == 0, "R2 blanking", int'(trip), 0);

    // phase A over the limit but no crossing since blanking ended (R3)
    repeat (6) send(-20000, 0, 0);
    idle(SETTLE + 2);
    check(mag_flags[0] == 0, "R3 no arm without crossing", int'(mag_flags[0]), 0);

    // arm phase C, then a spike with the slope test opened (R1)
    repeat (3) send(-20000, 0, -200);
    slim = 16'hFFFF;
    send(-20000, 0, 30000);
    repeat (4) send(-20000, 0, -200);
    idle(SETTLE + 2);
    check(mag_flags == 0 && slope_flags == 0, "R1 spike attenuated", int'(mag_flags), 0);

    // same spike with a tight slope limit, timing of the capture (R6 R7 R8)
    slim = 16'd3000;
    send(-20000, 0, 30000);
    idle(SETTLE - 1);
    check(slope_flags[2] == 0, "R7 one edge early", int'(slope_flags[2]), 0);
    idle(1);
    check(slope_flags[2] == 1, "R6 slope flag", int'(slope_flags[2]), 1);
    check(trip == 1, "R8 trip on slope", int'(trip), 1);
    check(mag_trip == 0, "R8 mag_trip low", int'(mag_trip), 0);

    // phase B: arm on a negative crossing, slow negative ramp (R4 R5)
    send(-20000, 400, -200);
    send(-20000, -400, -200);
    for (int v = -2000; v >= -16000; v -= 2000) repeat (3) send(-20000, v, -200);
    repeat (6) send(-20000, -16000, -200);
    idle(SETTLE + 1);
    check(mag_flags == 3'b010, "R5 magnitude on negative half", int'(mag_flags), 2);
    check(slope_flags[1] == 0, "R6 gentle ramp no slope flag", int'(slope_flags[1]), 0);
    check(mag_trip == 1, "R8 mag_trip", int'(mag_trip), 1);
    repeat (8) send(-20000, 0, -200);
    check(mag_flags[1] == 1, "R7 flag sticky", int'(mag_flags[1]), 1);

    // clear (R9)
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    check(trip == 0 && mag_flags == 0 && slope_flags == 0, "R9 clear", int'(trip), 0);
    repeat (4) send(20000, 0, 0);
    idle(BLANK);
    repeat (4) send(20000, 0, 0);
    idle(SETTLE + 2);
    check(mag_flags[0] == 0, "R9 arming restarted", int'(mag_flags[0]), 0);

    // most negative sample held: clamped magnitude 32767 (R4)
    slim = 16'hFFFF; mlim = 16'd32766;
    repeat (60) send(-32768, 0, 0);
    idle(SETTLE + 1);
    check(mag_flags[0] == 1, "R4 full-scale negative", int'(mag_flags[0]), 1);
    check(slope_flags == 0, "R6 open slope limit", int'(slope_flags), 0);

    idle(3);
    report();
  end
endmodule